// File: doc/BRIEF.md
# Configurable ADC Serial Output Formatter

This block serializes the parallel samples of one converter channel. Each sample becomes one serial word on a single data line. A frame marker and a data clock go out with it. Plain configuration inputs select four things: the serial word length, whether the word starts with its most or least significant bit, whether every output bit is inverted, and where the data clock edge sits inside each bit.

The block runs from a fast internal clock. One serial bit lasts twelve internal cycles, so one internal cycle is 30° of the bit period. The data clock position can be chosen in 60° steps, and it comes out of reset at 90°. Samples arrive through a valid/ready handshake, with one acceptance slot per serial word. When no sample is offered, the previous sample is sent again. Configuration is captured in the same slot, so a word never mixes two settings.

Top module: `adc_serial_fmt`

## Requirements
- R1: After reset the block sends the sample value 0 as 8-bit words, MSB first and not inverted, with the data clock at the 90° position.
- R2: Word length code `cfg_wlen` = 0, 1, 2, 3 selects 8, 10, 12 and 14 data bits. The serial word is 8, 10, 16 and 14 bits long, and each bit lasts 12 clock cycles.
- R3: The 8-bit sample occupies the most significant bits of the data field. Any data bits below it are 0.
- R4: With `cfg_wlen` = 2, four 0 bits follow the 12 data bits of every word. The inversion is applied after these bits are added.
- R5: With `cfg_lsb_first` = 0 the data field is sent from its top bit down. With 1 it is sent from bit 0 up. The trailing zero bits of R4 stay at the end of the word in both cases.
- R6: With `cfg_invert` = 1 every serial bit, padding included, is the complement of its value with `cfg_invert` = 0. This holds under either bit order.
- R7: `frame_clk` is high during the first half of the bits of each word and low during the second half. It rises together with the first bit.
- R8: `data_clk` has a period of 12 cycles and is high for 6 of them. It rises 2·k cycles after the data edge for `cfg_phase` = k (0..5), and 3 cycles after it for codes 6 and 7.
- R9: `in_ready` is high only in the last cycle of each word. A sample offered with `in_valid` in that cycle is sent in the next word. Otherwise the last accepted sample is repeated.
- R10: Configuration inputs are sampled only in the `in_ready` cycle. A change at any other time does not affect the word currently being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, 12 cycles per serial bit |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_data | input | SAMPLE_W | Parallel sample |
| in_ready | output | 1 | Sample accepted in this cycle if valid |
| cfg_wlen | input | 2 | Word length code |
| cfg_lsb_first | input | 1 | Send the least significant bit first |
| cfg_invert | input | 1 | Invert all serial bits |
| cfg_phase | input | 3 | Data clock position code |
| ser_out | output | 1 | Serial data |
| frame_clk | output | 1 | Word frame marker |
| data_clk | output | 1 | Bit clock at the chosen position |

## Verification
The hardest case to reach is a configuration or data change that arrives partway through a word. In that case the new settings must stay hidden until the next boundary. The stimulus therefore holds each combination of length, order, inversion and phase code for 150 cycles. That interval is not a multiple of any word length, so changes fall at many different offsets inside a word. Some combinations also withhold `in_valid` while `in_data` keeps changing, which tests that the previous sample is repeated.

// File: rtl/adc_serial_fmt.sv
module adc_serial_fmt #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                in_ready,
  input  logic [1:0]          cfg_wlen,
  input  logic                cfg_lsb_first,
  input  logic                cfg_invert,
  input  logic [2:0]          cfg_phase,
  output logic                ser_out,
  output logic                frame_clk,
  output logic                data_clk
);
  localparam int SUBS  = 12;
  localparam int SW    = 4;
  localparam int EXT_W = SAMPLE_W + 6;
  localparam int MAXN  = SAMPLE_W + 8;
  localparam int BW    = $clog2(MAXN);
  localparam logic [SW-1:0] DEF_OFF = SW'(3);

  logic [SW-1:0]       sub, off, ph;
  logic [BW-1:0]       bitn, pos;
  logic [SAMPLE_W-1:0] smp;
  logic [1:0]          wl;
  logic                lsb, inv, dbit;
  logic [BW:0]         dbits, nbits;
  logic [EXT_W-1:0]    field;
  logic                word_end;

  function automatic logic [SW-1:0] phase_off(input logic [2:0] code);
    return (code < 3'd6) ? {code, 1'b0} : DEF_OFF;
  endfunction

  assign dbits    = (BW+1)'(SAMPLE_W) + (BW+1)'({wl, 1'b0});
  assign nbits    = dbits + ((wl == 2'd2) ? (BW+1)'(4) : '0);
  assign word_end = ({1'b0, bitn} == nbits - 1'b1) && (sub == SW'(SUBS-1));
  assign in_ready = word_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub  <= '0;
      bitn <= '0;
      smp  <= '0;
      wl   <= '0;
      lsb  <= 1'b0;
      inv  <= 1'b0;
      off  <= DEF_OFF;
    end else if (sub == SW'(SUBS-1)) begin
      sub <= '0;
      if (word_end) begin
        bitn <= '0;
        if (in_valid) smp <= in_data;
        wl  <= cfg_wlen;
        lsb <= cfg_lsb_first;
        inv <= cfg_invert;
        off <= phase_off(cfg_phase);
      end else begin
        bitn <= bitn + 1'b1;
      end
    end else begin
      sub <= sub + 1'b1;
    end
  end

  assign field = {smp, 6'b0} >> (EXT_W - int'(dbits));
  assign pos   = lsb ? bitn : BW'(dbits - 1'b1 - {1'b0, bitn});
  assign dbit  = ({1'b0, bitn} < dbits) ? field[pos] : 1'b0;

  assign ser_out   = dbit ^ inv;
  assign frame_clk = {1'b0, bitn} < (nbits >> 1);
  assign ph        = (sub >= off) ? sub - off : sub + SW'(SUBS) - off;
  assign data_clk  = ph < SW'(SUBS/2);

  p_ready_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (sub == '0 && bitn == '0));

  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wl == 2'd2 && bitn >= BW'(SAMPLE_W+4)) |-> (ser_out == inv));

  p_frame_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bitn == '0) |-> frame_clk);

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($stable(wl) && $stable(lsb) && $stable(inv) && $stable(off)));

  p_dco_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(data_clk) && sub != '0) |-> (sub == off));
endmodule

// File: tb/test_adc_serial_fmt.sv
module test_adc_serial_fmt;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [7:0] in_data = 0;
  logic [1:0] cfg_wlen = 0;
  logic cfg_lsb_first = 0, cfg_invert = 0;
  logic [2:0] cfg_phase = 3'd6;
  logic in_ready, ser_out, frame_clk, data_clk;

  int compared = 0, mismatched = 0, cycles = 0;
  logic [2:0] exp_q[$];
  logic [7:0] held = 0;
  bit running = 0;

  always #2 clk = ~clk;

  adc_serial_fmt #(.SAMPLE_W(8)) i_adc_serial_fmt (
    .clk, .rst_n, .in_valid, .in_data, .in_ready, .cfg_wlen,
    .cfg_lsb_first, .cfg_invert, .cfg_phase, .ser_out, .frame_clk, .data_clk);

  // Expected per-cycle {data_clk, frame_clk, ser_out} of one word
  task automatic build_word(input logic [7:0] s, input int wl, input bit lsb,
                            input bit inv, input int pc);
    int d = 8 + 2*wl;
    int n = d + ((wl == 2) ? 4 : 0);
    int off = (pc < 6) ? 2*pc : 3;
    logic [15:0] v = 16'(s) << (d - 8);
    for (int b = 0; b < n; b++) begin
      logic bt = (b < d) ? (lsb ? v[b] : v[d-1-b]) : 1'b0;
      for (int c = 0; c < 12; c++)
        exp_q.push_back({(((c - off + 12) % 12) < 6), (b < n/2), bt ^ inv});
    end
  endtask

  task automatic cmp(input string req, input logic act, input logic ex);
    compared++;
    if (act !== ex) begin
      mismatched++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, cycles, act, ex);
    end
  endtask

  always @(negedge clk) if (running) begin
    cmp("R1 R2 R3 R4 R5 R6 R10 ser_out", ser_out, exp_q[0][0]);
    cmp("R7 frame_clk", frame_clk, exp_q[0][1]);
    cmp("R8 data_clk", data_clk, exp_q[0][2]);
    cmp("R9 in_ready", in_ready, exp_q.size() == 1);
  end

  always @(posedge clk) begin
    cycles++;
    if (running) begin
      void'(exp_q.pop_front());
      if (exp_q.size() == 0) begin
        if (in_valid) held = in_data;
        build_word(held, int'(cfg_wlen), cfg_lsb_first, cfg_invert, int'(cfg_phase));
      end
    end
    if (cycles > 190000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    build_word(8'h00, 0, 0, 0, 6);  // R1 reset state
    running = 1;
    in_data = 8'hC3;                 // not valid: R9 repeat of 0
    repeat (200) @(negedge clk);
    for (int k = 0; k < 128; k++) begin
      cfg_wlen      = 2'(k % 4);
      cfg_lsb_first = k[2];
      cfg_invert    = k[3];
      cfg_phase     = 3'(k / 16);
      in_valid      = (k % 3) != 0;
      in_data       = 8'(8'hA5 ^ (k * 37));
      repeat (150) @(negedge clk);
    end
    in_valid = 0;
    in_data  = 8'h5A;
    repeat (400) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule